// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block controls a bank of general-purpose pins, 64 or 96 of them, through a small synchronous register bus. The pins are handled in groups of 32, and each group uses one 32-bit word per feature. A feature block holds NGPIO/32 consecutive words. The blocks follow one another in a fixed order, so the byte address of any control word comes from the feature index and the pin group.

Software chooses the direction of each pin. It raises or lowers output pins through two write-one strobe registers, one for set and one for clear, so it never needs a read-modify-write of the output latch. It reads the synchronized pin levels directly.

Each pin has its own enable for rising edges and its own enable for falling edges. A detected edge sets a sticky status bit, which stays set until software writes a one to it. One registered interrupt line is active while any status bit is set.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction, output, edge-enable and status state is all zero, so pin_oe, pin_out, irq and bus_rdata are all 0.
- R2: Bus addresses are byte offsets. Feature f (0 level, 1 direction, 2 set, 3 clear, 4 rise-enable, 5 fall-enable, 6 status) with pin group g sits at f*(NGPIO/32)*4 + g*4, and pin p is bit p%32 of its word. Read data appears on bus_rdata in the cycle after the read is sampled, and it holds until the next read.
- R3: The level word returns the pin inputs after a two-flop synchronizer. A pin change is not visible to a read sampled at the second clock edge after the change.
- R4: A direction bit of 1 drives pin_oe high for that pin, and a direction bit of 0 makes the pin an input. The direction words read back as written.
- R5: Writing 1 to a bit of a set word drives that pin_out bit to 1, and writing 1 to a bit of a clear word drives it to 0. Zero bits have no effect. The set and clear words read as zero.
- R6: When a pin's rise-enable bit is 1, a synchronized 0-to-1 transition on that pin sets its status bit.
- R7: When a pin's fall-enable bit is 1, a 1-to-0 transition sets its status bit. With both enables set, either edge sets it. With neither enable set, edges leave the status unchanged.
- R8: Status bits are sticky. Writing 1 clears exactly the written bits in the addressed word. Writing back a value just read clears only the bits that were observed.
- R9: An enabled edge that lands in the same cycle as a write-one clear of its status bit leaves that bit set.
- R10: irq is a register that equals the OR of all status bits one cycle earlier.
- R11: Writes to the level word are ignored. Accesses at or beyond offset 7*(NGPIO/32)*4, or with bus_addr[1:0] not zero, read as zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NGPIO | Pin inputs, asynchronous |
| pin_out | output | NGPIO | Output latch |
| pin_oe | output | NGPIO | Output enable, one per pin |
| irq | output | 1 | Interrupt, active while any status bit is set |

## Verification
The assertions check several rules on every cycle. Pin outputs and output enables change only on a bus write. Status bits fall only on a write. No status bit rises while every edge enable is clear. irq follows the OR of the status bits. An out-of-range read returns zero.

Other behaviour can only be shown by the bench's scenarios:
- the exact address decode of every feature block;
- the delay through the synchronizer;
- which edge polarity triggers under each combination of enables;
- the precise cycle at which an edge collides with a clear.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NGPIO-1:0]  pin_in,
  output logic [NGPIO-1:0]  pin_out,
  output logic [NGPIO-1:0]  pin_oe,
  output logic              irq
);
  localparam int NW = NGPIO / 32;
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] NW_I  = IW'(NW);
  localparam logic [IW-1:0] END_I = IW'(7 * NW);

  localparam logic [IW-1:0] F_LVL = IW'(0);
  localparam logic [IW-1:0] F_DIR = IW'(1);
  localparam logic [IW-1:0] F_SET = IW'(2);
  localparam logic [IW-1:0] F_CLR = IW'(3);
  localparam logic [IW-1:0] F_REN = IW'(4);
  localparam logic [IW-1:0] F_FEN = IW'(5);
  localparam logic [IW-1:0] F_STS = IW'(6);

  logic [NGPIO-1:0] sync1, sync2, sync3;
  logic [NGPIO-1:0] dir_q, out_q, ren_q, fen_q, st_q;
  logic [NGPIO-1:0] wvec, gmask, evt, src;
  logic [IW-1:0]    widx, feat, grp;
  logic             hit, wr_hit, rd_hit;
  logic [31:0]      rword;

  assign widx   = bus_addr[ADDR_W-1:2];
  assign feat   = widx / NW_I;
  assign grp    = widx % NW_I;
  assign hit    = bus_sel && (widx < END_I) && (bus_addr[1:0] == 2'b00);
  assign wr_hit = hit && bus_wr;
  assign rd_hit = bus_sel && !bus_wr;

  always_comb begin
    wvec  = '0;
    gmask = '0;
    for (int g = 0; g < NW; g++) begin
      if (grp == IW'(g)) begin
        wvec[g*32 +: 32]  = bus_wdata;
        gmask[g*32 +: 32] = '1;
      end
    end
  end

  assign evt = (sync2 & ~sync3 & ren_q) | (~sync2 & sync3 & fen_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
    end else if (wr_hit) begin
      if (feat == F_DIR) dir_q <= (dir_q & ~gmask) | wvec;
      if (feat == F_REN) ren_q <= (ren_q & ~gmask) | wvec;
      if (feat == F_FEN) fen_q <= (fen_q & ~gmask) | wvec;
      if (feat == F_SET) out_q <= out_q | wvec;
      if (feat == F_CLR) out_q <= out_q & ~wvec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= (st_q & ~((wr_hit && feat == F_STS) ? wvec : '0)) | evt;
      irq  <= |st_q;
    end
  end

  always_comb begin
    case (feat)
      F_LVL:   src = sync2;
      F_DIR:   src = dir_q;
      F_REN:   src = ren_q;
      F_FEN:   src = fen_q;
      F_STS:   src = st_q;
      default: src = '0;
    endcase
    rword = '0;
    for (int g = 0; g < NW; g++)
      if (grp == IW'(g)) rword = src[g*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= hit ? rword : 32'h0;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

module gpio_bank_chk #(
  parameter int NGPIO  = 64,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NGPIO-1:0]  pin_out,
  input logic [NGPIO-1:0]  pin_oe,
  input logic [NGPIO-1:0]  ren,
  input logic [NGPIO-1:0]  fen,
  input logic [NGPIO-1:0]  status,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] END_B = ADDR_W'(7 * (NGPIO / 32) * 4);

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pin_out));
  assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pin_oe));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> (($past(status) & ~status) == '0));
  assert_no_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ren | fen) == '0) |=> ((status & ~$past(status)) == '0));
  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|status) |=> irq);
  assert_irq_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|status) |=> !irq);
  assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr >= END_B) |=> (bus_rdata == 32'h0));
endmodule

bind gpio_bank gpio_bank_chk #(.NGPIO(NGPIO), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .ren(ren_q), .fen(fen_q), .status(st_q), .irq(irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int NGPIO = 64;
  localparam int AW    = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NGPIO-1:0] pin_in = '0;
  logic [NGPIO-1:0] pin_out, pin_oe;
  logic            irq;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  gpio_bank #(.NGPIO(NGPIO), .ADDR_W(AW)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // Address map for 64 pins: level 00/04, dir 08/0C, set 10/14, clr 18/1C,
  // rise 20/24, fall 28/2C, status 30/34, end 38.
  // Entry: {write, addr, wdata, expected read}
  localparam logic [72:0] VEC [18] = '{
    {1'b1, 8'h08, 32'h0000_00FF, 32'h0},          // R4
    {1'b0, 8'h08, 32'h0,         32'h0000_00FF},  // R4
    {1'b1, 8'h10, 32'h0000_00A5, 32'h0},          // R5
    {1'b0, 8'h10, 32'h0,         32'h0},          // R5 set reads zero
    {1'b1, 8'h14, 32'h8000_0001, 32'h0},          // R5
    {1'b1, 8'h18, 32'h0000_0081, 32'h0},          // R5
    {1'b1, 8'h1C, 32'h0,         32'h0},          // R5 zero no effect
    {1'b1, 8'h0C, 32'hF000_0000, 32'h0},          // R2
    {1'b0, 8'h0C, 32'h0,         32'hF000_0000},  // R2
    {1'b0, 8'h18, 32'h0,         32'h0},          // R5 clr reads zero
    {1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0},          // R11
    {1'b0, 8'h38, 32'h0,         32'h0},          // R11
    {1'b0, 8'h3C, 32'h0,         32'h0},          // R11
    {1'b1, 8'h09, 32'hFFFF_FFFF, 32'h0},          // R11 misaligned
    {1'b0, 8'h08, 32'h0,         32'h0000_00FF},  // R11
    {1'b1, 8'h20, 32'h0000_000F, 32'h0},          // R2
    {1'b0, 8'h20, 32'h0,         32'h0000_000F},  // R2
    {1'b1, 8'h2C, 32'h0000_0003, 32'h0}           // R2
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    #1 bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq", {63'b0, irq}, 64'b0);
    chk("R1 rdata", {32'b0, bus_rdata}, 64'b0);
    rd(8'h30, d); chk("R1 status", {32'b0, d}, 64'b0);

    for (int i = 0; i < 18; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], d);
        chk($sformatf("R2 vector %0d", i), {32'b0, d}, {32'b0, VEC[i][31:0]});
      end
    end
    chk("R5 pin_out", pin_out, {32'h8000_0001, 32'h0000_0024});
    chk("R4 pin_oe", pin_oe, {32'hF000_0000, 32'h0000_00FF});

    @(negedge clk) pin_in = 64'h1234_5678_9ABC_DEF0;
    rd(8'h00, d); chk("R3 sync delay", {32'b0, d}, 64'b0);
    wait_cyc(3);
    rd(8'h00, d); chk("R3 level0", {32'b0, d}, {32'b0, 32'h9ABC_DEF0});
    rd(8'h04, d); chk("R3 level1", {32'b0, d}, {32'b0, 32'h1234_5678});
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R11 level write ignored", {32'b0, d}, {32'b0, 32'h9ABC_DEF0});
    rd(8'h30, d); chk("R7 disabled edges", {32'b0, d}, 64'b0);
    rd(8'h34, d); chk("R7 disabled edges w1", {32'b0, d}, 64'b0);
    chk("R10 irq idle", {63'b0, irq}, 64'b0);

    @(negedge clk) pin_in[1] = 1'b1;
    wait_cyc(4);
    rd(8'h30, d); chk("R6 rising", {32'b0, d}, {32'b0, 32'h2});
    chk("R10 irq set", {63'b0, irq}, 64'b1);

    wr(8'h2C, 32'h9);
    @(negedge clk) pin_in[35] = 1'b0;
    wait_cyc(4);
    rd(8'h34, d); chk("R7 falling", {32'b0, d}, {32'b0, 32'h8});

    wr(8'h20, 32'h10F);
    wr(8'h28, 32'h100);
    @(negedge clk) pin_in[8] = 1'b1;
    wait_cyc(4);
    rd(8'h30, d); chk("R7 both rise", {32'b0, d}, {32'b0, 32'h102});
    wr(8'h30, d);
    rd(8'h30, d); chk("R8 w1c readback", {32'b0, d}, 64'b0);
    rd(8'h34, d); chk("R8 other word kept", {32'b0, d}, {32'b0, 32'h8});
    chk("R10 irq held", {63'b0, irq}, 64'b1);
    wr(8'h34, 32'h8);
    wait_cyc(2);
    chk("R10 irq clear", {63'b0, irq}, 64'b0);

    @(negedge clk) pin_in[8] = 1'b0;
    wait_cyc(4);
    rd(8'h30, d); chk("R7 both fall", {32'b0, d}, {32'b0, 32'h100});

    @(negedge clk) pin_in[8] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(8'h30, 32'h100);
    rd(8'h30, d); chk("R9 edge beats clear", {32'b0, d}, {32'b0, 32'h100});
    wr(8'h30, 32'h100);
    rd(8'h30, d); chk("R8 final clear", {32'b0, d}, 64'b0);
    wait_cyc(2);
    chk("R10 irq final", {63'b0, irq}, 64'b0);
    chk("R5 pin_out stable", pin_out, {32'h8000_0001, 32'h0000_0024});

    finish_run();
  end
endmodule